// File: doc/BRIEF.md
# Per-Class Pipe Issue Allocator

This block sits after instruction decode and decides, every clock, which execution unit each of up to four decoded instructions is sent to. The machine has four integer pipes in two clusters, each cluster owning one upper and one lower pipe. The units are numbered U0, U1, L0, L1, followed by one floating-point adder (FA), one floating-point multiplier (FM) and two floating-point store units (FS0, FS1). Every instruction carries an operation-class code. The class fixes which units may take it and how long, or at which later cycle, it keeps them.

Placement goes strictly in program order, from slot 0 (oldest) to slot 3. Each slot sees the reservations already made by older slots in the same cycle, together with a per-unit future-occupancy shift register that holds claims made in earlier cycles. The first valid instruction that cannot be placed is stalled, and so is every younger instruction. The stall output tells the front end to present the stalled slots again.

Top module: `pipe_issue_alloc`

## Requirements
- R1: After reset every unit is free. With no valid slot, no grant is given and stall is low. Four class-0 (integer arithmetic) instructions then go to units 0, 1, 2, 3.
- R2: Unit codes are U0=0, U1=1, L0=2, L1=3, FA=4, FM=5, FS0=6, FS1=7. Among the eligible free pipes, the lowest-numbered one is granted, in the order U0, U1, L0, L1. Integer arithmetic (code 0) may use any integer pipe.
- R3: Integer load (1), integer store (2), FP load (3) and int-to-FP move (4) are granted only L0 or L1. Shift (5) and integer branch (6) are granted only U0 or U1.
- R4: Integer multiply (7) goes only to U1, motion-video (8) only to U0, call (9) only to L0 and barrier (10) only to L1.
- R5: A slot that is not valid is never granted and does not block younger slots. Once a valid slot cannot be placed, it and every younger slot get no grant in that cycle, and stall is high. Stall is low when every valid slot is granted.
- R6: Conditional integer move (11) needs one integer pipe in the issue cycle and in the next cycle. No other instruction receives that pipe in the next cycle.
- R7: FP store (12) and FP-to-int move (13) are granted FS0 or FS1 in the issue cycle. They also reserve L0 or L1 (lowest free first) two cycles later, so that a lower pipe is not available to others in that cycle.
- R8: A multi-unit instruction (14) is granted only when all eight units are free and no older slot was granted in the same cycle. Its reported unit is 0, and no younger slot is granted with it.
- R9: FP divide single (17) and double (18) hold FA for 9 and 12 cycles. FP square root single (19) and double (20) hold it for 15 and 30 cycles. For an issue in cycle t, FA can next be granted in cycle t+N.
- R10: FP conditional move (21) uses FA in cycle t and again in cycle t+4. FA stays free for others in cycles t+1 to t+3 and is busy in t+4.
- R11: FP add (15) occupies FA and FP multiply (16) occupies FM, each for the issue cycle only.
- R12: Class codes 22 to 31 are reserved. They are never granted and are treated as unplaceable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, clears all reservations |
| slot_vld | input | SLOTS | Slot holds an instruction this cycle (bit 0 is oldest) |
| slot_cls | input | SLOTS x 5 | Operation class code of each slot |
| slot_go | output | SLOTS | Slot is issued this cycle |
| slot_unit | output | SLOTS x 3 | Unit granted to each slot (meaningful when slot_go is set) |
| stall | output | 1 | Some valid slot was not issued this cycle |

## Verification
The properties assume that the class inputs stay stable through each cycle and are sampled at the clock edge. They also rely on the occupancy after reset coming only from instructions the block itself granted, so a hold property may use the previous cycle's grant as its cause. The stimulus changes inputs only on the falling edge and starts every scenario after enough idle cycles for the longest reservation to drain. Reserved class codes are applied on purpose, because the property covering them states that they never receive a grant.

// File: rtl/issue_pkg.sv
package issue_pkg;

   localparam int NINT   = 4;
   localparam int NUNIT  = 8;
   localparam int UNIT_W = 3;
   localparam int CLS_W  = 5;

   localparam int U_U0  = 0;
   localparam int U_U1  = 1;
   localparam int U_L0  = 2;
   localparam int U_L1  = 3;
   localparam int U_FA  = 4;
   localparam int U_FM  = 5;
   localparam int U_FS0 = 6;
   localparam int U_FS1 = 7;

   typedef enum logic [CLS_W-1:0] {
      C_ARITH   = 5'd0,
      C_ILOAD   = 5'd1,
      C_ISTORE  = 5'd2,
      C_FLOAD   = 5'd3,
      C_ITOF    = 5'd4,
      C_SHIFT   = 5'd5,
      C_IBR     = 5'd6,
      C_IMUL    = 5'd7,
      C_MVI     = 5'd8,
      C_CALL    = 5'd9,
      C_BARRIER = 5'd10,
      C_ICMOV   = 5'd11,
      C_FSTORE  = 5'd12,
      C_FTOI    = 5'd13,
      C_MULTI   = 5'd14,
      C_FADD    = 5'd15,
      C_FMUL    = 5'd16,
      C_FDIV_S  = 5'd17,
      C_FDIV_D  = 5'd18,
      C_FSQRT_S = 5'd19,
      C_FSQRT_D = 5'd20,
      C_FCMOV   = 5'd21
   } cls_e;

   // integer pipe eligibility, bit p set when pipe p may take the class
   function automatic logic [NINT-1:0] int_mask(input logic [CLS_W-1:0] c);
      case (c)
         C_ARITH, C_ICMOV:                    return 4'b1111;
         C_ILOAD, C_ISTORE, C_FLOAD, C_ITOF:  return 4'b1100;
         C_SHIFT, C_IBR:                      return 4'b0011;
         C_IMUL:                              return 4'b0010;
         C_MVI:                               return 4'b0001;
         C_CALL:                              return 4'b0100;
         C_BARRIER:                           return 4'b1000;
         default:                             return 4'b0000;
      endcase
   endfunction

endpackage

// File: rtl/issue_occ_table.sv
module issue_occ_table
   import issue_pkg::*;
#(
   parameter int DEPTH = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUNIT-1:0][DEPTH-1:0]       claim_i,
   output logic [NUNIT-1:0][DEPTH-1:0]       occ_o
);

   // one future-occupancy line per unit, bit k = busy k cycles ahead
   for (genvar u = 0; u < NUNIT; u++) begin : g_unit
      always_ff @(posedge clk) begin
         if (!rst_n) occ_o[u] <= '0;
         else        occ_o[u] <= {1'b0, claim_i[u][DEPTH-1:1]};
      end
   end

endmodule

// File: rtl/issue_slot_place.sv
module issue_slot_place
   import issue_pkg::*;
#(
   parameter int DEPTH      = 32,
   parameter int FST_LAG    = 2,
   parameter int FCMOV_GAP  = 4,
   parameter int FDIVS_CYC  = 9,
   parameter int FDIVD_CYC  = 12,
   parameter int FSQRTS_CYC = 15,
   parameter int FSQRTD_CYC = 30
) (
   input  logic                        en_i,
   input  logic                        first_i,
   input  logic [CLS_W-1:0]            cls_i,
   input  logic [NUNIT-1:0][DEPTH-1:0] occ_i,
   output logic                        fit_o,
   output logic [UNIT_W-1:0]           unit_o,
   output logic [NUNIT-1:0][DEPTH-1:0] occ_o
);

   function automatic logic [DEPTH-1:0] hold_bits(input int n);
      logic [DEPTH-1:0] v;
      v = '0;
      for (int k = 0; k < DEPTH; k++) if (k < n) v[k] = 1'b1;
      return v;
   endfunction

   cls_e                        c;
   logic [NINT-1:0]             imask;
   logic                        pair;
   logic                        fa_use;
   logic [DEPTH-1:0]            fa_pat;
   logic                        fs_ok, lo_ok, all_free;
   logic [UNIT_W-1:0]           fs_sel, lo_sel;
   logic                        fit;
   logic [UNIT_W-1:0]           unit;
   logic [NUNIT-1:0][DEPTH-1:0] res;

   always_comb begin
      c        = cls_e'(cls_i);
      imask    = int_mask(cls_i);
      pair     = (c == C_ICMOV);
      fa_use   = 1'b0;
      fa_pat   = '0;
      fs_ok    = 1'b0;
      lo_ok    = 1'b0;
      fs_sel   = '0;
      lo_sel   = '0;
      all_free = 1'b1;
      fit      = 1'b0;
      unit     = '0;
      res      = '0;
      case (c)
         C_FADD:    begin fa_use = 1'b1; fa_pat = hold_bits(1);          end
         C_FDIV_S:  begin fa_use = 1'b1; fa_pat = hold_bits(FDIVS_CYC);  end
         C_FDIV_D:  begin fa_use = 1'b1; fa_pat = hold_bits(FDIVD_CYC);  end
         C_FSQRT_S: begin fa_use = 1'b1; fa_pat = hold_bits(FSQRTS_CYC); end
         C_FSQRT_D: begin fa_use = 1'b1; fa_pat = hold_bits(FSQRTD_CYC); end
         C_FCMOV:   begin
            fa_use            = 1'b1;
            fa_pat[0]         = 1'b1;
            fa_pat[FCMOV_GAP] = 1'b1;
         end
         default: ;
      endcase

      if (|imask) begin
         // descending scan leaves the lowest-numbered free pipe selected
         for (int p = NINT-1; p >= 0; p--) begin
            if (imask[p] && !occ_i[p][0] && (!pair || !occ_i[p][1])) begin
               fit  = 1'b1;
               unit = UNIT_W'(p);
            end
         end
         if (fit) begin
            res[unit][0] = 1'b1;
            if (pair) res[unit][1] = 1'b1;
         end
      end else if (fa_use) begin
         if ((occ_i[U_FA] & fa_pat) == '0) begin
            fit       = 1'b1;
            unit      = UNIT_W'(U_FA);
            res[U_FA] = fa_pat;
         end
      end else if (c == C_FMUL) begin
         if (!occ_i[U_FM][0]) begin
            fit          = 1'b1;
            unit         = UNIT_W'(U_FM);
            res[U_FM][0] = 1'b1;
         end
      end else if (c == C_FSTORE || c == C_FTOI) begin
         for (int f = 1; f >= 0; f--) begin
            if (!occ_i[U_FS0+f][0]) begin
               fs_ok  = 1'b1;
               fs_sel = UNIT_W'(U_FS0 + f);
            end
         end
         for (int l = 1; l >= 0; l--) begin
            if (!occ_i[U_L0+l][FST_LAG]) begin
               lo_ok  = 1'b1;
               lo_sel = UNIT_W'(U_L0 + l);
            end
         end
         if (fs_ok && lo_ok) begin
            fit                  = 1'b1;
            unit                 = fs_sel;
            res[fs_sel][0]       = 1'b1;
            res[lo_sel][FST_LAG] = 1'b1;
         end
      end else if (c == C_MULTI) begin
         for (int u = 0; u < NUNIT; u++) if (occ_i[u][0]) all_free = 1'b0;
         if (all_free && first_i) begin
            fit  = 1'b1;
            unit = UNIT_W'(U_U0);
            for (int u = 0; u < NUNIT; u++) res[u][0] = 1'b1;
         end
      end
   end

   assign fit_o  = fit;
   assign unit_o = unit;
   assign occ_o  = (en_i && fit) ? (occ_i | res) : occ_i;

endmodule

// File: rtl/pipe_issue_alloc.sv
module pipe_issue_alloc
   import issue_pkg::*;
#(
   parameter int SLOTS      = 4,
   parameter int DEPTH      = 32,
   parameter int FST_LAG    = 2,
   parameter int FCMOV_GAP  = 4,
   parameter int FDIVS_CYC  = 9,
   parameter int FDIVD_CYC  = 12,
   parameter int FSQRTS_CYC = 15,
   parameter int FSQRTD_CYC = 30
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [SLOTS-1:0]              slot_vld,
   input  logic [SLOTS-1:0][CLS_W-1:0]   slot_cls,
   output logic [SLOTS-1:0]              slot_go,
   output logic [SLOTS-1:0][UNIT_W-1:0]  slot_unit,
   output logic                          stall
);

   localparam int LONGEST = (FSQRTD_CYC > FSQRTS_CYC) ? FSQRTD_CYC : FSQRTS_CYC;

   if (SLOTS < 1) begin : g_bad_slots
      $error("pipe_issue_alloc: SLOTS must be at least 1");
   end
   if (DEPTH < LONGEST || DEPTH <= FCMOV_GAP || DEPTH <= FST_LAG) begin : g_bad_depth
      $error("pipe_issue_alloc: DEPTH too short for the longest reservation");
   end
   if (FDIVS_CYC < 1 || FDIVD_CYC < 1 || FSQRTS_CYC < 1 || FST_LAG < 1 || FCMOV_GAP < 1)
   begin : g_bad_cyc
      $error("pipe_issue_alloc: hold and lag values must be positive");
   end

   logic [NUNIT-1:0][DEPTH-1:0] occ_q;
   logic [NUNIT-1:0][DEPTH-1:0] occ_chain [SLOTS+1];
   logic                        blk       [SLOTS+1];
   logic                        any_go    [SLOTS+1];
   logic [SLOTS-1:0]            fit;

   assign occ_chain[0] = occ_q;
   assign blk[0]       = 1'b0;
   assign any_go[0]    = 1'b0;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic en;
      assign en = slot_vld[s] & ~blk[s];

      issue_slot_place #(
         .DEPTH      (DEPTH),
         .FST_LAG    (FST_LAG),
         .FCMOV_GAP  (FCMOV_GAP),
         .FDIVS_CYC  (FDIVS_CYC),
         .FDIVD_CYC  (FDIVD_CYC),
         .FSQRTS_CYC (FSQRTS_CYC),
         .FSQRTD_CYC (FSQRTD_CYC)
      ) u_place (
         .en_i    (en),
         .first_i (~any_go[s]),
         .cls_i   (slot_cls[s]),
         .occ_i   (occ_chain[s]),
         .fit_o   (fit[s]),
         .unit_o  (slot_unit[s]),
         .occ_o   (occ_chain[s+1])
      );

      assign slot_go[s]  = en & fit[s];
      assign blk[s+1]    = blk[s] | (slot_vld[s] & ~fit[s]);
      assign any_go[s+1] = any_go[s] | slot_go[s];
   end

   assign stall = blk[SLOTS];

   issue_occ_table #(.DEPTH(DEPTH)) u_occ (
      .clk     (clk),
      .rst_n   (rst_n),
      .claim_i (occ_chain[SLOTS]),
      .occ_o   (occ_q)
   );

endmodule

// File: rtl/pipe_issue_alloc_chk.sv
module pipe_issue_alloc_chk
   import issue_pkg::*;
#(
   parameter int SLOTS = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [SLOTS-1:0]              slot_vld,
   input logic [SLOTS-1:0][CLS_W-1:0]   slot_cls,
   input logic [SLOTS-1:0]              slot_go,
   input logic [SLOTS-1:0][UNIT_W-1:0]  slot_unit,
   input logic                          stall
);

   a_r5_no_stall_all_go: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_go == slot_vld) |-> !stall);

   for (genvar i = 0; i < SLOTS; i++) begin : g_i
      a_r5_go_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
         slot_go[i] |-> slot_vld[i]);

      if (i > 0) begin : g_ord
         a_r5_program_order: assert property (@(posedge clk) disable iff (!rst_n)
            slot_go[i] |-> (slot_go[i-1] || !slot_vld[i-1]));
      end

      a_r3_lower_only: assert property (@(posedge clk) disable iff (!rst_n)
         (slot_go[i] && (slot_cls[i] == C_ILOAD || slot_cls[i] == C_ISTORE ||
                         slot_cls[i] == C_FLOAD || slot_cls[i] == C_ITOF))
         |-> (slot_unit[i] == 3'd2 || slot_unit[i] == 3'd3));

      a_r3_upper_only: assert property (@(posedge clk) disable iff (!rst_n)
         (slot_go[i] && (slot_cls[i] == C_SHIFT || slot_cls[i] == C_IBR))
         |-> (slot_unit[i] == 3'd0 || slot_unit[i] == 3'd1));

      a_r4_mul_on_u1: assert property (@(posedge clk) disable iff (!rst_n)
         (slot_go[i] && slot_cls[i] == C_IMUL) |-> slot_unit[i] == 3'd1);

      a_r8_multi_alone: assert property (@(posedge clk) disable iff (!rst_n)
         (slot_go[i] && slot_cls[i] == C_MULTI) |-> $countones(slot_go) == 1);

      a_r12_reserved_never: assert property (@(posedge clk) disable iff (!rst_n)
         slot_go[i] |-> slot_cls[i] <= C_FCMOV);

      for (genvar j = 0; j < SLOTS; j++) begin : g_j
         if (j > i) begin : g_pair
            a_r2_distinct_units: assert property (@(posedge clk) disable iff (!rst_n)
               (slot_go[i] && slot_go[j]) |-> slot_unit[i] != slot_unit[j]);
         end

         a_r6_cmov_second_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_go[i] && slot_cls[i] == C_ICMOV)
            |=> !(slot_go[j] && slot_unit[j] == $past(slot_unit[i])));

         a_r9_fa_held: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_go[i] && (slot_cls[i] == C_FDIV_S || slot_cls[i] == C_FDIV_D ||
                            slot_cls[i] == C_FSQRT_S || slot_cls[i] == C_FSQRT_D))
            |=> !(slot_go[j] && slot_unit[j] == 3'd4));
      end
   end

endmodule

bind pipe_issue_alloc pipe_issue_alloc_chk #(.SLOTS(SLOTS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .slot_vld  (slot_vld),
   .slot_cls  (slot_cls),
   .slot_go   (slot_go),
   .slot_unit (slot_unit),
   .stall     (stall)
);

// File: tb/pipe_issue_alloc_bench.sv
module pipe_issue_alloc_bench;
   import issue_pkg::*;

   localparam int SLOTS = 4;

   logic                         clk = 1'b0;
   logic                         rst_n = 1'b0;
   logic [SLOTS-1:0]             slot_vld = '0;
   logic [SLOTS-1:0][CLS_W-1:0]  slot_cls = '0;
   logic [SLOTS-1:0]             slot_go;
   logic [SLOTS-1:0][UNIT_W-1:0] slot_unit;
   logic                         stall;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   pipe_issue_alloc u_pipe_issue_alloc (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_vld  (slot_vld),
      .slot_cls  (slot_cls),
      .slot_go   (slot_go),
      .slot_unit (slot_unit),
      .stall     (stall)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one issue cycle: drive after the falling edge, sample 1 ns later
   task automatic apply(input logic [3:0] v, input logic [4:0] c0, input logic [4:0] c1,
                        input logic [4:0] c2, input logic [4:0] c3);
      @(negedge clk);
      slot_vld    = v;
      slot_cls[0] = c0;
      slot_cls[1] = c1;
      slot_cls[2] = c2;
      slot_cls[3] = c3;
      #1;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) apply(4'b0000, C_ARITH, C_ARITH, C_ARITH, C_ARITH);
   endtask

   task automatic t_reset;
      idle(1);
      chk("R1 idle go", slot_go, 0);
      chk("R1 idle stall", stall, 0);
      apply(4'b1111, C_ARITH, C_ARITH, C_ARITH, C_ARITH);
      chk("R1 go", slot_go, 4'b1111);
      chk("R1 stall", stall, 0);
      chk("R2 slot0 unit", slot_unit[0], 0);
      chk("R2 slot1 unit", slot_unit[1], 1);
      chk("R2 slot2 unit", slot_unit[2], 2);
      chk("R2 slot3 unit", slot_unit[3], 3);
      idle(2);
   endtask

   task automatic t_lower_upper;
      apply(4'b1111, C_ILOAD, C_FLOAD, C_SHIFT, C_ISTORE);
      chk("R3 go", slot_go, 4'b0111);
      chk("R3 stall", stall, 1);
      chk("R3 load unit", slot_unit[0], 2);
      chk("R3 fload unit", slot_unit[1], 3);
      chk("R3 shift unit", slot_unit[2], 0);
      apply(4'b0111, C_IBR, C_ITOF, C_SHIFT, C_ARITH);
      chk("R3 branch/itof go", slot_go, 4'b0111);
      chk("R3 branch unit", slot_unit[0], 0);
      chk("R3 itof unit", slot_unit[1], 2);
      chk("R3 shift second upper", slot_unit[2], 1);
      idle(2);
   endtask

   task automatic t_fixed;
      apply(4'b1111, C_IMUL, C_MVI, C_CALL, C_BARRIER);
      chk("R4 go", slot_go, 4'b1111);
      chk("R4 mul unit", slot_unit[0], 1);
      chk("R4 mvi unit", slot_unit[1], 0);
      chk("R4 call unit", slot_unit[2], 2);
      chk("R4 barrier unit", slot_unit[3], 3);
      apply(4'b0011, C_IMUL, C_IMUL, C_ARITH, C_ARITH);
      chk("R4 second mul stalls", slot_go, 4'b0001);
      chk("R4 stall", stall, 1);
      apply(4'b0011, C_MVI, C_ARITH, C_ARITH, C_ARITH);
      chk("R2 next free after U0", slot_unit[1], 1);
      chk("R2 go", slot_go, 4'b0011);
      idle(2);
   endtask

   task automatic t_order;
      apply(4'b0111, C_MVI, C_MVI, C_ARITH, C_ARITH);
      chk("R5 younger blocked", slot_go, 4'b0001);
      chk("R5 stall", stall, 1);
      apply(4'b1101, C_ARITH, C_ARITH, C_ARITH, C_ARITH);
      chk("R5 hole go", slot_go, 4'b1101);
      chk("R5 hole stall", stall, 0);
      chk("R5 slot2 unit", slot_unit[2], 1);
      chk("R5 slot3 unit", slot_unit[3], 2);
      idle(2);
   endtask

   task automatic t_icmov;
      apply(4'b0001, C_ICMOV, C_ARITH, C_ARITH, C_ARITH);
      chk("R6 cmov go", slot_go, 4'b0001);
      chk("R6 cmov unit", slot_unit[0], 0);
      apply(4'b1111, C_ARITH, C_ARITH, C_ARITH, C_ARITH);
      chk("R6 second cycle go", slot_go, 4'b0111);
      chk("R6 second cycle unit", slot_unit[0], 1);
      chk("R6 stall", stall, 1);
      apply(4'b1111, C_ARITH, C_ARITH, C_ARITH, C_ARITH);
      chk("R6 released", slot_go, 4'b1111);
      idle(2);
   endtask

   task automatic t_fst;
      apply(4'b0111, C_FSTORE, C_FTOI, C_FSTORE, C_ARITH);
      chk("R7 go", slot_go, 4'b0011);
      chk("R7 fst unit", slot_unit[0], 6);
      chk("R7 ftoi unit", slot_unit[1], 7);
      chk("R7 stall", stall, 1);
      apply(4'b0011, C_ILOAD, C_ILOAD, C_ARITH, C_ARITH);
      chk("R7 lower free at +1", slot_go, 4'b0011);
      apply(4'b0001, C_ILOAD, C_ARITH, C_ARITH, C_ARITH);
      chk("R7 lower busy at +2", slot_go, 4'b0000);
      chk("R7 stall at +2", stall, 1);
      apply(4'b0001, C_ILOAD, C_ARITH, C_ARITH, C_ARITH);
      chk("R7 lower back at +3", slot_go, 4'b0001);
      chk("R7 unit at +3", slot_unit[0], 2);
      idle(4);
   endtask

   task automatic t_multi;
      apply(4'b0011, C_ARITH, C_MULTI, C_ARITH, C_ARITH);
      chk("R8 multi not first", slot_go, 4'b0001);
      chk("R8 stall", stall, 1);
      apply(4'b0011, C_MULTI, C_ARITH, C_ARITH, C_ARITH);
      chk("R8 multi alone", slot_go, 4'b0001);
      chk("R8 multi unit", slot_unit[0], 0);
      apply(4'b1111, C_ARITH, C_ARITH, C_ARITH, C_ARITH);
      chk("R8 one cycle only", slot_go, 4'b1111);
      apply(4'b0001, C_FDIV_S, C_ARITH, C_ARITH, C_ARITH);
      apply(4'b0001, C_MULTI, C_ARITH, C_ARITH, C_ARITH);
      chk("R8 blocked by busy FA", slot_go, 4'b0000);
      idle(12);
   endtask

   task automatic t_fa_hold(input logic [4:0] cls, input int n, input string req);
      apply(4'b0001, cls, C_ARITH, C_ARITH, C_ARITH);
      chk({req, " issue"}, slot_go, 4'b0001);
      chk({req, " unit"}, slot_unit[0], 4);
      for (int k = 1; k <= n; k++) begin
         apply(4'b0011, C_FMUL, C_FADD, C_ARITH, C_ARITH);
         chk("R11 fmul on FM", slot_go[0] ? slot_unit[0] : -1, 5);
         chk({req, " FA window"}, slot_go[1], (k == n) ? 1 : 0);
      end
      chk("R11 fadd unit", slot_unit[1], 4);
      idle(2);
   endtask

   task automatic t_fcmov;
      apply(4'b0001, C_FCMOV, C_ARITH, C_ARITH, C_ARITH);
      chk("R10 issue unit", slot_unit[0], 4);
      for (int k = 1; k <= 5; k++) begin
         apply(4'b0001, C_FADD, C_ARITH, C_ARITH, C_ARITH);
         chk("R10 FA gap", slot_go[0], (k == 4) ? 0 : 1);
      end
      idle(2);
   endtask

   task automatic t_reserved;
      apply(4'b0011, 5'd25, C_ARITH, C_ARITH, C_ARITH);
      chk("R12 reserved go", slot_go, 4'b0000);
      chk("R12 reserved stall", stall, 1);
      apply(4'b0001, 5'd31, C_ARITH, C_ARITH, C_ARITH);
      chk("R12 code 31", slot_go, 4'b0000);
      idle(2);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_lower_upper;
      t_fixed;
      t_order;
      t_icmov;
      t_fst;
      t_multi;
      t_fa_hold(C_FDIV_S, 9, "R9 fdiv single");
      t_fa_hold(C_FDIV_D, 12, "R9 fdiv double");
      t_fa_hold(C_FSQRT_S, 15, "R9 sqrt single");
      t_fa_hold(C_FSQRT_D, 30, "R9 sqrt double");
      t_fcmov;
      t_reserved;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule